// File: doc/BRIEF.md
# I2C message transfer sequencer

This block turns a short list of I2C message descriptors into one combined bus transaction. It does not drive the bus wires itself. Instead it issues byte-level commands (start, repeated start, stop, write a byte, read a byte) to a command engine and waits for one response per command. The engine handles all electrical timing. The sequencer decides the order of these commands. It forms 7-bit and ten-bit address bytes. It retries an address that no device acknowledges, tolerates NAKs when a message asks for that, and always closes the bus with a STOP before it reports the result.

A host loads the descriptors, sets the message count and the retry limit, and pulses `go_i`. The block reads each descriptor through `msg_idx_o`. Each descriptor carries a 10-bit address, four flags and a byte length. Write data enters on a valid/ready stream and read data leaves on another. Each finished message raises a pulse with its byte count. The whole transaction ends with a one-cycle `done_o` and a 2-bit result code.

Top module: `i2cseq_top`

## Requirements
- R1: Command codes on `cmd_op_o` are 0 START, 1 RESTART, 2 STOP, 3 WRITE, 4 READ. A transaction always begins with exactly one START and always ends with a STOP. `done_o` pulses only after the response to that STOP arrives.
- R2: For a 7-bit message, the address byte is `{addr[6:0], rd}`, where rd is flag bit 0 (1 = read).
- R3: For a ten-bit message (flag bit 1), the block sends two bytes. The first is `{5'b11110, addr[9:8], 1'b0}` and the second is `addr[7:0]`.
- R4: For a ten-bit read, the two address bytes are followed by a RESTART and then the byte `{5'b11110, addr[9:8], 1'b1}`.
- R5: Every message after the first is preceded by a RESTART and its own address phase, unless it carries the no-start flag (bit 3). A no-start message goes straight to its data bytes.
- R6: A NAK on the first address byte (or on the ten-bit read header) triggers a retry. The block issues STOP, waits at least GAP_CYCLES cycles, issues START and resends the byte. It retries up to `retry_limit_i` times. When the retries are used up, the block reports NODEV (code 1) with a byte count of 0.
- R7: For a message with the ignore-NAK flag (bit 2), the retry count is zero, a NAK on an address does not stop the message, and a NAK on a write data byte still counts that byte as sent.
- R8: In a read message, every byte except the last is read with ACK (`cmd_nack_o` = 0), and the last byte is read with NACK. Each received byte appears on the rx stream in order and is held until it is accepted.
- R9: A NAK on a write data byte, in a message without ignore-NAK, ends the transaction with IO (code 2). The byte count then shows only the acknowledged bytes.
- R10: A response flagged as timeout ends the transaction with TIMEOUT (code 3), after a STOP.
- R11: At most one command is outstanding at a time. A non-write command that is stalled by `cmd_ready_i` keeps its code until it is accepted.
- R12: On success the result is OK (code 0). `byte_count_o` holds the byte count of the last message handled. `msg_done_o` pulses once per completed message. Write bytes are taken from the tx stream in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | Start a transaction (sampled while idle) |
| msg_count_i | input | IDX_W | Number of messages in the list |
| retry_limit_i | input | RETRY_W | Address retries allowed |
| msg_idx_o | output | IDX_W | Index of the descriptor being read |
| desc_addr_i | input | 10 | Target address of the indexed message |
| desc_flags_i | input | 4 | Flags: 0 read, 1 ten-bit, 2 ignore NAK, 3 no start |
| desc_len_i | input | LEN_W | Byte length of the indexed message |
| cmd_valid_o | output | 1 | Command offered to the engine |
| cmd_ready_i | input | 1 | Engine accepts the command |
| cmd_op_o | output | 3 | Command code |
| cmd_byte_o | output | 8 | Byte to write |
| cmd_nack_o | output | 1 | Answer the read byte with NACK |
| rsp_valid_i | input | 1 | Engine response for the outstanding command |
| rsp_ack_i | input | 1 | Byte was acknowledged |
| rsp_timeout_i | input | 1 | Command timed out |
| rsp_byte_i | input | 8 | Byte that was read |
| tx_valid_i | input | 1 | Write data available |
| tx_data_i | input | 8 | Write data |
| tx_ready_o | output | 1 | Write data consumed |
| rx_valid_o | output | 1 | Read data available |
| rx_data_o | output | 8 | Read data |
| rx_ready_i | input | 1 | Read data accepted |
| busy_o | output | 1 | Transaction in progress |
| msg_done_o | output | 1 | One message completed |
| byte_count_o | output | LEN_W | Bytes completed in the current or last message |
| done_o | output | 1 | Transaction finished (one-cycle pulse) |
| status_o | output | 2 | Result code: 0 OK, 1 NODEV, 2 IO, 3 TIMEOUT |

## Verification
The hardest path to reach is the address retry loop. To get there, the same address byte must be refused several times in a row, the STOP/gap/START sequence must happen in between, and the retry budget must run out on exactly the last attempt. The bench models the command engine. Its responder refuses a set number of address bytes, which it recognises as any write that directly follows a START or RESTART. Separately, it refuses the data write at a chosen position and flags a timeout on a chosen command. With these three controls, one table can cover retry success, exhausted retries, ignore-NAK, data-NAK aborts and timeouts. The bench also timestamps every accepted command, so it can measure the gap between the STOP and the following START.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_RESTART = 3'd1,
        OP_STOP    = 3'd2,
        OP_WRITE   = 3'd3,
        OP_READ    = 3'd4
    } cmd_op_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_NODEV   = 2'd1,
        ST_IO      = 2'd2,
        ST_TIMEOUT = 2'd3
    } status_e;

    typedef enum logic [3:0] {
        PH_IDLE, PH_START, PH_NEXT, PH_RESTART, PH_ADDR1, PH_ADDR2,
        PH_RS10, PH_ADDR3, PH_DATA, PH_RX, PH_RSTOP, PH_GAP, PH_RSTART,
        PH_STOP
    } phase_e;

    typedef struct packed {
        logic nostart;
        logic ign_nak;
        logic ten;
        logic rd;
    } msg_flags_t;

    function automatic logic [7:0] ten_header(input logic [1:0] hi, input logic rd);
        return {5'b11110, hi, rd};
    endfunction

    function automatic logic [7:0] short_addr(input logic [6:0] a, input logic rd);
        return {a, rd};
    endfunction

endpackage

// File: rtl/i2cseq_addr_former.sv
module i2cseq_addr_former
    import i2cseq_pkg::*;
(
    input  logic [9:0] addr_i,
    input  logic       rd_i,
    input  logic       ten_i,
    input  logic [1:0] sel_i,
    output logic [7:0] byte_o
);
    always_comb begin
        unique case (sel_i)
            2'd1:    byte_o = addr_i[7:0];
            2'd2:    byte_o = ten_header(addr_i[9:8], 1'b1);
            default: byte_o = ten_i ? ten_header(addr_i[9:8], 1'b0)
                                    : short_addr(addr_i[6:0], rd_i);
        endcase
    end
endmodule

// File: rtl/i2cseq_gap_timer.sv
module i2cseq_gap_timer #(
    parameter int CYCLES = 16,
    localparam int CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic expired_o
);
    logic [CW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start_i) begin
            cnt_q <= CW'(CYCLES - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top
    import i2cseq_pkg::*;
#(
    parameter int MAX_MSGS   = 4,
    parameter int LEN_W      = 8,
    parameter int RETRY_W    = 3,
    parameter int GAP_CYCLES = 16,
    localparam int IDX_W     = $clog2(MAX_MSGS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               go_i,
    input  logic [IDX_W-1:0]   msg_count_i,
    input  logic [RETRY_W-1:0] retry_limit_i,
    output logic [IDX_W-1:0]   msg_idx_o,
    input  logic [9:0]         desc_addr_i,
    input  logic [3:0]         desc_flags_i,
    input  logic [LEN_W-1:0]   desc_len_i,
    output logic               cmd_valid_o,
    input  logic               cmd_ready_i,
    output logic [2:0]         cmd_op_o,
    output logic [7:0]         cmd_byte_o,
    output logic               cmd_nack_o,
    input  logic               rsp_valid_i,
    input  logic               rsp_ack_i,
    input  logic               rsp_timeout_i,
    input  logic [7:0]         rsp_byte_i,
    input  logic               tx_valid_i,
    input  logic [7:0]         tx_data_i,
    output logic               tx_ready_o,
    output logic               rx_valid_o,
    output logic [7:0]         rx_data_o,
    input  logic               rx_ready_i,
    output logic               busy_o,
    output logic               msg_done_o,
    output logic [LEN_W-1:0]   byte_count_o,
    output logic               done_o,
    output logic [1:0]         status_o
);
    phase_e             phase_q;
    logic               wait_q, ret_third_q, done_q, msgdone_q;
    logic [IDX_W-1:0]   idx_q;
    logic [LEN_W-1:0]   cnt_q;
    logic [RETRY_W-1:0] tries_q;
    status_e            status_q;
    logic [7:0]         rx_q;
    msg_flags_t         flg;
    logic [1:0]         addr_sel;
    logic [7:0]         addr_byte;
    logic               acc, rsp, ok, last_byte, gap_start, gap_done;
    logic [LEN_W-1:0]   cnt_inc;

    assign flg       = msg_flags_t'(desc_flags_i);
    assign acc       = cmd_valid_o && cmd_ready_i;
    assign rsp       = wait_q && rsp_valid_i;
    assign ok        = rsp_ack_i || flg.ign_nak;
    assign cnt_inc   = cnt_q + 1'b1;
    assign last_byte = (cnt_inc == desc_len_i);
    assign gap_start = rsp && !rsp_timeout_i && (phase_q == PH_RSTOP);
    assign addr_sel  = (phase_q == PH_ADDR2) ? 2'd1 :
                       (phase_q == PH_ADDR3) ? 2'd2 : 2'd0;

    i2cseq_addr_former u_addr (
        .addr_i (desc_addr_i),
        .rd_i   (flg.rd),
        .ten_i  (flg.ten),
        .sel_i  (addr_sel),
        .byte_o (addr_byte)
    );

    i2cseq_gap_timer #(.CYCLES(GAP_CYCLES)) u_gap (
        .clk       (clk),
        .rst       (rst),
        .start_i   (gap_start),
        .expired_o (gap_done)
    );

    always_comb begin
        cmd_valid_o = 1'b0;
        cmd_op_o    = OP_WRITE;
        cmd_byte_o  = addr_byte;
        cmd_nack_o  = 1'b0;
        tx_ready_o  = 1'b0;
        unique case (phase_q)
            PH_START, PH_RSTART: begin
                cmd_valid_o = !wait_q;
                cmd_op_o    = OP_START;
            end
            PH_RESTART, PH_RS10: begin
                cmd_valid_o = !wait_q;
                cmd_op_o    = OP_RESTART;
            end
            PH_ADDR1, PH_ADDR2, PH_ADDR3: cmd_valid_o = !wait_q;
            PH_RSTOP, PH_STOP: begin
                cmd_valid_o = !wait_q;
                cmd_op_o    = OP_STOP;
            end
            PH_DATA: begin
                if (flg.rd) begin
                    cmd_valid_o = !wait_q;
                    cmd_op_o    = OP_READ;
                    cmd_byte_o  = '0;
                    cmd_nack_o  = last_byte;
                end else begin
                    cmd_valid_o = !wait_q && tx_valid_i;
                    cmd_byte_o  = tx_data_i;
                    tx_ready_o  = !wait_q && cmd_ready_i;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            wait_q      <= 1'b0;
            ret_third_q <= 1'b0;
            done_q      <= 1'b0;
            msgdone_q   <= 1'b0;
            idx_q       <= '0;
            cnt_q       <= '0;
            tries_q     <= '0;
            status_q    <= ST_OK;
            rx_q        <= '0;
        end else begin
            done_q    <= 1'b0;
            msgdone_q <= 1'b0;
            if (acc) wait_q <= 1'b1;
            if (rsp) wait_q <= 1'b0;
            if (rsp && phase_q == PH_STOP) begin
                phase_q <= PH_IDLE;
                done_q  <= 1'b1;
            end else if (rsp && rsp_timeout_i) begin
                status_q <= ST_TIMEOUT;
                phase_q  <= PH_STOP;
            end else begin
                unique case (phase_q)
                    PH_IDLE: if (go_i) begin
                        idx_q    <= '0;
                        cnt_q    <= '0;
                        status_q <= ST_OK;
                        phase_q  <= PH_START;
                    end
                    PH_START:   if (rsp) phase_q <= PH_NEXT;
                    PH_RSTART:  if (rsp) phase_q <= ret_third_q ? PH_ADDR3 : PH_ADDR1;
                    PH_RESTART: if (rsp) phase_q <= PH_ADDR1;
                    PH_NEXT: begin
                        if (idx_q == msg_count_i) begin
                            phase_q <= PH_STOP;
                        end else begin
                            cnt_q       <= '0;
                            tries_q     <= flg.ign_nak ? '0 : retry_limit_i;
                            ret_third_q <= 1'b0;
                            if (flg.nostart) begin
                                if (desc_len_i == '0) begin
                                    idx_q     <= idx_q + 1'b1;
                                    msgdone_q <= 1'b1;
                                end else begin
                                    phase_q <= PH_DATA;
                                end
                            end else begin
                                phase_q <= (idx_q == '0) ? PH_ADDR1 : PH_RESTART;
                            end
                        end
                    end
                    PH_ADDR1, PH_ADDR3: if (rsp) begin
                        if (ok) begin
                            if (phase_q == PH_ADDR1 && flg.ten) begin
                                phase_q <= PH_ADDR2;
                            end else if (desc_len_i == '0) begin
                                idx_q     <= idx_q + 1'b1;
                                msgdone_q <= 1'b1;
                                phase_q   <= PH_NEXT;
                            end else begin
                                phase_q <= PH_DATA;
                            end
                        end else if (tries_q != '0) begin
                            tries_q     <= tries_q - 1'b1;
                            ret_third_q <= (phase_q == PH_ADDR3);
                            phase_q     <= PH_RSTOP;
                        end else begin
                            status_q <= ST_NODEV;
                            phase_q  <= PH_STOP;
                        end
                    end
                    PH_ADDR2: if (rsp) begin
                        if (!ok) begin
                            status_q <= ST_NODEV;
                            phase_q  <= PH_STOP;
                        end else if (flg.rd) begin
                            phase_q <= PH_RS10;
                        end else if (desc_len_i == '0) begin
                            idx_q     <= idx_q + 1'b1;
                            msgdone_q <= 1'b1;
                            phase_q   <= PH_NEXT;
                        end else begin
                            phase_q <= PH_DATA;
                        end
                    end
                    PH_RS10: if (rsp) begin
                        tries_q <= flg.ign_nak ? '0 : retry_limit_i;
                        phase_q <= PH_ADDR3;
                    end
                    PH_DATA: if (rsp) begin
                        if (flg.rd) begin
                            rx_q    <= rsp_byte_i;
                            phase_q <= PH_RX;
                        end else if (ok) begin
                            cnt_q <= cnt_inc;
                            if (last_byte) begin
                                idx_q     <= idx_q + 1'b1;
                                msgdone_q <= 1'b1;
                                phase_q   <= PH_NEXT;
                            end
                        end else begin
                            status_q <= ST_IO;
                            phase_q  <= PH_STOP;
                        end
                    end
                    PH_RX: if (rx_ready_i) begin
                        cnt_q <= cnt_inc;
                        if (last_byte) begin
                            idx_q     <= idx_q + 1'b1;
                            msgdone_q <= 1'b1;
                            phase_q   <= PH_NEXT;
                        end else begin
                            phase_q <= PH_DATA;
                        end
                    end
                    PH_RSTOP: if (rsp) phase_q <= PH_GAP;
                    PH_GAP:   if (gap_done) phase_q <= PH_RSTART;
                    default: ;
                endcase
            end
        end
    end

    assign msg_idx_o    = idx_q;
    assign rx_valid_o   = (phase_q == PH_RX);
    assign rx_data_o    = rx_q;
    assign busy_o       = (phase_q != PH_IDLE);
    assign msg_done_o   = msgdone_q;
    assign byte_count_o = cnt_q;
    assign done_o       = done_q;
    assign status_o     = status_q;
endmodule

// File: rtl/i2cseq_checker.sv
module i2cseq_checker
    import i2cseq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid_o,
    input logic             cmd_ready_i,
    input logic [2:0]       cmd_op_o,
    input logic             rsp_valid_i,
    input logic             tx_ready_o,
    input logic             tx_valid_i,
    input logic             rx_valid_o,
    input logic             rx_ready_i,
    input logic [7:0]       rx_data_o,
    input logic             done_o,
    input logic [1:0]       status_o,
    input logic [LEN_W-1:0] byte_count_o
);
    logic outstanding_q, last_stop_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding_q <= 1'b0;
            last_stop_q   <= 1'b0;
        end else begin
            if (cmd_valid_o && cmd_ready_i) begin
                outstanding_q <= 1'b1;
                last_stop_q   <= (cmd_op_o == OP_STOP);
            end else if (rsp_valid_i) begin
                outstanding_q <= 1'b0;
            end
        end
    end

    assert_single_outstanding_R11: assert property (@(posedge clk) disable iff (rst)
        outstanding_q |-> !cmd_valid_o);

    assert_cmd_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_o && !cmd_ready_i && cmd_op_o != OP_WRITE) |=>
        (cmd_valid_o && $stable(cmd_op_o)));

    assert_stop_before_done_R1: assert property (@(posedge clk) disable iff (rst)
        done_o |-> last_stop_q);

    assert_rx_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));

    assert_tx_pairs_write_R12: assert property (@(posedge clk) disable iff (rst)
        (tx_ready_o && tx_valid_i) |-> (cmd_valid_o && cmd_op_o == OP_WRITE));

    assert_nodev_no_bytes_R6: assert property (@(posedge clk) disable iff (rst)
        (done_o && status_o == ST_NODEV) |-> (byte_count_o == '0));
endmodule

bind i2cseq_top i2cseq_checker #(.LEN_W(LEN_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_ready_i  (cmd_ready_i),
    .cmd_op_o     (cmd_op_o),
    .rsp_valid_i  (rsp_valid_i),
    .tx_ready_o   (tx_ready_o),
    .tx_valid_i   (tx_valid_i),
    .rx_valid_o   (rx_valid_o),
    .rx_ready_i   (rx_ready_i),
    .rx_data_o    (rx_data_o),
    .done_o       (done_o),
    .status_o     (status_o),
    .byte_count_o (byte_count_o)
);

// File: tb/i2cseq_top_tb.sv
module i2cseq_top_tb;
    localparam int MAX_MSGS = 4;
    localparam int LEN_W    = 8;
    localparam int RETRY_W  = 3;
    localparam int GAP      = 16;
    localparam int IDX_W    = $clog2(MAX_MSGS + 1);

    typedef struct packed {
        logic [9:0] addr;
        logic [3:0] flags;
        logic [7:0] len;
        logic [2:0] retry;
        logic [2:0] nack_a;
        logic [7:0] nack_d;
        logic [7:0] to_at;
        logic [1:0] st;
        logic [7:0] bytes;
        logic [7:0] ncmd;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VEC [NVEC] = '{
        '{10'h052, 4'h0, 8'd2, 3'd0, 3'd0, 8'hFF, 8'hFF, 2'd0, 8'd2, 8'd5},
        '{10'h013, 4'h1, 8'd3, 3'd0, 3'd0, 8'hFF, 8'hFF, 2'd0, 8'd3, 8'd6},
        '{10'h021, 4'h0, 8'd1, 3'd2, 3'd1, 8'hFF, 8'hFF, 2'd0, 8'd1, 8'd7},
        '{10'h021, 4'h0, 8'd1, 3'd1, 3'd3, 8'hFF, 8'hFF, 2'd1, 8'd0, 8'd6},
        '{10'h021, 4'h4, 8'd1, 3'd3, 3'd1, 8'hFF, 8'hFF, 2'd0, 8'd1, 8'd4},
        '{10'h040, 4'h0, 8'd3, 3'd0, 3'd0, 8'd1,  8'hFF, 2'd2, 8'd1, 8'd5},
        '{10'h040, 4'h4, 8'd3, 3'd0, 3'd0, 8'd1,  8'hFF, 2'd0, 8'd3, 8'd6},
        '{10'h2A5, 4'h2, 8'd1, 3'd0, 3'd0, 8'hFF, 8'hFF, 2'd0, 8'd1, 8'd5},
        '{10'h1C3, 4'h3, 8'd1, 3'd0, 3'd0, 8'hFF, 8'hFF, 2'd0, 8'd1, 8'd7},
        '{10'h011, 4'h0, 8'd2, 3'd0, 3'd0, 8'hFF, 8'd2,  2'd3, 8'd0, 8'd4},
        '{10'h021, 4'h0, 8'd1, 3'd0, 3'd1, 8'hFF, 8'hFF, 2'd1, 8'd0, 8'd3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic               go = 1'b0;
    logic [IDX_W-1:0]   msg_count = '0;
    logic [RETRY_W-1:0] retry_limit = '0;
    logic [IDX_W-1:0]   msg_idx;
    logic [9:0]         desc_addr;
    logic [3:0]         desc_flags;
    logic [LEN_W-1:0]   desc_len;
    logic               cmd_valid, cmd_nack, tx_ready, rx_valid, busy, msg_done, done;
    logic [2:0]         cmd_op;
    logic [7:0]         cmd_byte, rx_data;
    logic [LEN_W-1:0]   byte_count;
    logic [1:0]         status;
    logic               cmd_ready = 1'b1;
    logic               rsp_valid, rsp_ack, rsp_timeout;
    logic [7:0]         rsp_byte, tx_data;

    logic [9:0] d_addr  [MAX_MSGS];
    logic [3:0] d_flags [MAX_MSGS];
    logic [7:0] d_len   [MAX_MSGS];

    always_comb begin
        desc_addr = '0; desc_flags = '0; desc_len = '0;
        if (int'(msg_idx) < MAX_MSGS) begin
            desc_addr  = d_addr[msg_idx[1:0]];
            desc_flags = d_flags[msg_idx[1:0]];
            desc_len   = d_len[msg_idx[1:0]];
        end
    end

    i2cseq_top #(.MAX_MSGS(MAX_MSGS), .LEN_W(LEN_W), .RETRY_W(RETRY_W), .GAP_CYCLES(GAP)) u_dut (
        .clk(clk), .rst(rst), .go_i(go), .msg_count_i(msg_count), .retry_limit_i(retry_limit),
        .msg_idx_o(msg_idx), .desc_addr_i(desc_addr), .desc_flags_i(desc_flags),
        .desc_len_i(desc_len), .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
        .cmd_op_o(cmd_op), .cmd_byte_o(cmd_byte), .cmd_nack_o(cmd_nack),
        .rsp_valid_i(rsp_valid), .rsp_ack_i(rsp_ack), .rsp_timeout_i(rsp_timeout),
        .rsp_byte_i(rsp_byte), .tx_valid_i(1'b1), .tx_data_i(tx_data), .tx_ready_o(tx_ready),
        .rx_valid_o(rx_valid), .rx_data_o(rx_data), .rx_ready_i(1'b1), .busy_o(busy),
        .msg_done_o(msg_done), .byte_count_o(byte_count), .done_o(done), .status_o(status)
    );

    // Engine model and logging
    logic       clr = 1'b0;
    logic [2:0] cfg_nack_a = '0;
    logic [7:0] cfg_nack_d = 8'hFF, cfg_to = 8'hFF;
    logic [7:0] ncmd, wr_idx, nrx, nmsg_done, tx_cnt, cyc;
    logic [2:0] nack_used, prev_op;
    logic [2:0] log_op   [64];
    logic [7:0] log_byte [64];
    logic       log_nack [64];
    logic [7:0] log_cyc  [64];
    logic [7:0] rx_log   [8];

    assign tx_data = 8'h30 + tx_cnt;

    always @(posedge clk) begin
        rsp_valid   <= 1'b0;
        rsp_timeout <= 1'b0;
        cyc         <= cyc + 1'b1;
        if (rst || clr) begin
            ncmd <= 0; wr_idx <= 0; nrx <= 0; nmsg_done <= 0; tx_cnt <= 0;
            nack_used <= 0; prev_op <= 3'd2; cyc <= 0; rsp_ack <= 1'b1; rsp_byte <= 0;
        end else begin
            if (msg_done) nmsg_done <= nmsg_done + 1'b1;
            if (tx_ready) tx_cnt <= tx_cnt + 1'b1;
            if (rx_valid) begin
                rx_log[nrx[2:0]] <= rx_data;
                nrx <= nrx + 1'b1;
            end
            if (cmd_valid && cmd_ready) begin
                log_op[ncmd[5:0]]   <= cmd_op;
                log_byte[ncmd[5:0]] <= cmd_byte;
                log_nack[ncmd[5:0]] <= cmd_nack;
                log_cyc[ncmd[5:0]]  <= cyc;
                rsp_valid   <= 1'b1;
                rsp_byte    <= 8'hA0 + ncmd;
                rsp_timeout <= (ncmd == cfg_to);
                rsp_ack     <= 1'b1;
                if (cmd_op == 3'd3) begin
                    if (prev_op == 3'd0 || prev_op == 3'd1) begin
                        if (nack_used < cfg_nack_a) begin
                            rsp_ack   <= 1'b0;
                            nack_used <= nack_used + 1'b1;
                        end
                    end else begin
                        rsp_ack <= (wr_idx != cfg_nack_d);
                        wr_idx  <= wr_idx + 1'b1;
                    end
                end
                prev_op <= cmd_op;
                ncmd    <= ncmd + 1'b1;
            end
        end
    end

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int first_addr(input logic [9:0] a, input logic [3:0] f);
        return f[1] ? {5'b11110, a[9:8], 1'b0} : {a[6:0], f[0]};
    endfunction

    logic [1:0] r_st;
    logic [7:0] r_bc;

    task automatic run(input int nm, input int rl, input int na, input int nd, input int to);
        bit found;
        @(negedge clk);
        cfg_nack_a = 3'(na); cfg_nack_d = 8'(nd); cfg_to = 8'(to);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        msg_count = IDX_W'(nm); retry_limit = RETRY_W'(rl); go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        found = 1'b0;
        for (int w = 0; w < 3000; w++) begin
            if (done) begin found = 1'b1; break; end
            @(negedge clk);
        end
        if (!found) begin
            checks++; fails++;
            $display("FAIL R1 watchdog actual=no-done expected=done");
        end
        r_st = status; r_bc = byte_count;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < MAX_MSGS; i++) begin
            d_addr[i] = '0; d_flags[i] = '0; d_len[i] = '0;
        end
        repeat (3) @(negedge clk);
        // reset state (R1, R12)
        chk("R1 reset cmd_valid", int'(cmd_valid), 0);
        chk("R12 reset done", int'(done), 0);
        chk("R12 reset busy", int'(busy), 0);
        rst = 1'b0;

        // vector table, one message each
        for (int v = 0; v < NVEC; v++) begin
            d_addr[0] = VEC[v].addr; d_flags[0] = VEC[v].flags; d_len[0] = VEC[v].len;
            run(1, int'(VEC[v].retry), int'(VEC[v].nack_a), int'(VEC[v].nack_d), int'(VEC[v].to_at));
            chk($sformatf("R12 R9 R10 vec%0d status", v), int'(r_st), int'(VEC[v].st));
            chk($sformatf("R12 R7 vec%0d bytes", v), int'(r_bc), int'(VEC[v].bytes));
            chk($sformatf("R6 R7 vec%0d command count", v), int'(ncmd), int'(VEC[v].ncmd));
            chk($sformatf("R1 vec%0d first START", v), int'(log_op[0]), 0);
            chk($sformatf("R1 vec%0d final STOP", v), int'(log_op[ncmd[5:0] - 6'd1]), 2);
            chk($sformatf("R2 R3 vec%0d address byte", v), int'(log_byte[1]),
                first_addr(VEC[v].addr, VEC[v].flags));
        end

        // R3 R4: ten-bit read byte order
        d_addr[0] = 10'h1C3; d_flags[0] = 4'h3; d_len[0] = 8'd1;
        run(1, 0, 0, 255, 255);
        chk("R3 low address byte", int'(log_byte[2]), 8'hC3);
        chk("R4 restart after address", int'(log_op[3]), 1);
        chk("R4 read header", int'(log_byte[4]), 8'hF3);
        chk("R8 single read last NACK", int'(log_nack[5]), 1);

        // R6: retry sequence and gap; R12 tx order
        d_addr[0] = 10'h021; d_flags[0] = 4'h0; d_len[0] = 8'd2;
        run(1, 2, 1, 255, 255);
        chk("R6 stop after nack", int'(log_op[2]), 2);
        chk("R6 start after gap", int'(log_op[3]), 0);
        chk("R6 gap length ok", int'((log_cyc[3] - log_cyc[2]) >= GAP), 1);
        chk("R6 address resent", int'(log_byte[4]), 8'h42);
        chk("R12 tx byte 0", int'(log_byte[5]), 8'h30);
        chk("R12 tx byte 1", int'(log_byte[6]), 8'h31);

        // R5 R8: write then read with repeated start
        d_addr[0] = 10'h02C; d_flags[0] = 4'h0; d_len[0] = 8'd1;
        d_addr[1] = 10'h02C; d_flags[1] = 4'h1; d_len[1] = 8'd2;
        run(2, 0, 0, 255, 255);
        chk("R5 combined command count", int'(ncmd), 8);
        chk("R5 restart between messages", int'(log_op[3]), 1);
        chk("R2 read address byte", int'(log_byte[4]), 8'h59);
        chk("R8 first read ACK", int'(log_nack[5]), 0);
        chk("R8 last read NACK", int'(log_nack[6]), 1);
        chk("R8 rx byte 0", int'(rx_log[0]), 8'hA5);
        chk("R8 rx byte 1", int'(rx_log[1]), 8'hA6);
        chk("R12 message pulses", int'(nmsg_done), 2);
        chk("R12 combined status", int'(r_st), 0);
        chk("R12 last message bytes", int'(r_bc), 2);

        // R5: no-start continuation
        d_addr[0] = 10'h033; d_flags[0] = 4'h0; d_len[0] = 8'd1;
        d_addr[1] = 10'h033; d_flags[1] = 4'h8; d_len[1] = 8'd2;
        run(2, 0, 0, 255, 255);
        chk("R5 no-start command count", int'(ncmd), 6);
        chk("R5 no-start data op", int'(log_op[3]), 3);
        chk("R5 no-start data byte", int'(log_byte[3]), 8'h31);

        // R1: empty list
        run(0, 0, 0, 255, 255);
        chk("R1 empty list commands", int'(ncmd), 2);
        chk("R1 empty list stop", int'(log_op[1]), 2);
        chk("R12 empty list status", int'(r_st), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule